// File: doc/BRIEF.md
# Triggered DMA Request Burst Generator

This block holds a bank of independent request generators that turn events into DMA requests. Each generator watches one line of a shared trigger bus, picked by a select field. When that line shows the edge the generator is set to look for, the generator starts a burst: a programmed number of DMA requests, sent one at a time. Each request is a level that stays high until the DMA acknowledges it. The requests go to the request router, and the router sends them on to DMA channels.

Each generator has its own setup, written through a small shared write port: enable, trigger select, edge mode, burst length and interrupt enable. A trigger edge that arrives while a burst is still in progress is not queued. It is dropped and recorded in a sticky per-generator overrun flag. Software clears that flag by writing one to it. The flags that software has unmasked are ORed into a single interrupt line.

Top module: `trg_burst_reqgen`

## Requirements
- R1: After reset every generator is disabled, and all request outputs, overrun flags and the interrupt are low.
- R2: A generator reacts only to the trigger line whose index is in its select field. Select values of 26 or more read as a constant low line. Activity on any other line has no effect on it.
- R3: The edge mode field encodes 2'b00 = never trigger, 2'b01 = rising edge, 2'b10 = falling edge, 2'b11 = either edge. An edge is a change of the selected line between two consecutive clock samples.
- R4: One accepted edge produces exactly N+1 requests, where N is the 5-bit burst length field. Each request stays high while its acknowledge is low.
- R5: An acknowledge taken while more requests remain keeps the request high in the next cycle, as the next request of the burst. The acknowledge of the last request drives it low in the next cycle.
- R6: An acknowledge given while the request is low has no effect.
- R7: An enabled edge that arrives while the request is high sets that generator's overrun flag. That edge is dropped, and the burst in progress keeps its remaining count.
- R8: An overrun flag stays set until a one is written to its clear bit. A new overrun in the same cycle as the clear keeps it set.
- R9: The interrupt is high exactly when at least one generator has both its overrun flag and its interrupt enable set.
- R10: A disabled generator takes no edges. Clearing the enable during a burst drops the request in the cycle after the enable goes low, and the rest of the burst is discarded.
- R11: In the cycle a generator's configuration is written, it takes no edge. Edge detection afterwards compares against a sample of the newly selected line taken in that write cycle.
- R12: An accepted edge at one clock edge raises the request at that same clock edge, so the request is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Generator addressed by the write |
| cfg_en | input | 1 | Enable value to write |
| cfg_trig_sel | input | 5 | Trigger line select to write |
| cfg_edge | input | 2 | Edge mode to write |
| cfg_nreq | input | 5 | Burst length minus one to write |
| cfg_irq_en | input | 1 | Overrun interrupt enable to write |
| trig_i | input | 26 | Trigger bus |
| ovr_clr_i | input | 4 | Write-one-to-clear strobes for the overrun flags |
| ack_i | input | 4 | DMA acknowledge per generator |
| req_o | output | 4 | DMA request per generator |
| ovr_o | output | 4 | Sticky overrun flag per generator |
| irq_o | output | 1 | Combined overrun interrupt |

## Verification
The hardest case to reach is an overrun that lands on the exact cycle of a boundary: the last acknowledge of a burst, the cycle of a flag clear, or a configuration write. The bench drives each of these directly, one cycle at a time. It then runs several thousand cycles of random trigger toggles, acknowledges, clears and rewrites against a cycle-level bench model. Burst lengths in that run are kept short and triggers toggle often, so that edges frequently arrive while a burst is still in progress.

// File: rtl/trg_burst_pkg.sv
`timescale 1ns/1ps
package trg_burst_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    function automatic logic edge_match(edge_mode_e mode, logic cur, logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        unique case (mode)
            EDGE_RISE: edge_match = rise;
            EDGE_FALL: edge_match = fall;
            EDGE_ANY:  edge_match = rise | fall;
            default:   edge_match = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trg_edge_det.sv
`timescale 1ns/1ps
module trg_edge_det
    import trg_burst_pkg::*;
#(
    parameter int TRIG_W = 26,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_W-1:0] trig_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  edge_mode_e        mode_i,
    input  logic              reload_i,
    input  logic [SEL_W-1:0]  reload_sel_i,
    output logic              hit_o
);
    localparam int PAD_W = 1 << SEL_W;

    typedef struct packed {
        logic prev;
    } det_st_t;

    det_st_t st_d, st_q;
    logic [PAD_W-1:0] bus_pad;
    logic cur_bit;
    logic new_bit;

    always_comb begin
        bus_pad = PAD_W'(trig_i);
        cur_bit = bus_pad[sel_i];
        new_bit = bus_pad[reload_sel_i];
        st_d    = st_q;
        if (reload_i) begin
            st_d.prev = new_bit;
            hit_o     = 1'b0;
        end else begin
            st_d.prev = cur_bit;
            hit_o     = edge_match(mode_i, cur_bit, st_q.prev);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/trg_burst_fsm.sv
`timescale 1ns/1ps
module trg_burst_fsm #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] nreq_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic             ovr_set_o
);
    typedef struct packed {
        logic             req;
        logic [CNT_W-1:0] left;
    } burst_st_t;

    burst_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ovr_set_o = start_i & st_q.req;
        if (!en_i) begin
            st_d.req  = 1'b0;
            st_d.left = '0;
        end else if (st_q.req) begin
            if (ack_i) begin
                if (st_q.left == '0) st_d.req = 1'b0;
                else                 st_d.left = st_q.left - CNT_W'(1);
            end
        end else if (start_i) begin
            st_d.req  = 1'b1;
            st_d.left = nreq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

endmodule

// File: rtl/trg_gen_chan.sv
`timescale 1ns/1ps
module trg_gen_chan
    import trg_burst_pkg::*;
#(
    parameter int TRIG_W = 26,
    parameter int SEL_W  = 5,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [1:0]        wr_edge_i,
    input  logic [CNT_W-1:0]  wr_nreq_i,
    input  logic              wr_ie_i,
    input  logic [TRIG_W-1:0] trig_i,
    input  logic              ovr_clr_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic              ovr_o,
    output logic              ie_o,
    output logic              en_o
);
    typedef struct packed {
        logic             en;
        logic             ie;
        logic [SEL_W-1:0] sel;
        edge_mode_e       mode;
        logic [CNT_W-1:0] nreq;
        logic             ovr;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic hit;
    logic start;
    logic ovr_set;

    trg_edge_det #(.TRIG_W(TRIG_W), .SEL_W(SEL_W)) edge_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .sel_i        (st_q.sel),
        .mode_i       (st_q.mode),
        .reload_i     (wr_i),
        .reload_sel_i (wr_sel_i),
        .hit_o        (hit)
    );

    assign start = hit & st_q.en;

    trg_burst_fsm #(.CNT_W(CNT_W)) burst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (st_q.en),
        .start_i   (start),
        .nreq_i    (st_q.nreq),
        .ack_i     (ack_i),
        .req_o     (req_o),
        .ovr_set_o (ovr_set)
    );

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.en   = wr_en_i;
            st_d.ie   = wr_ie_i;
            st_d.sel  = wr_sel_i;
            st_d.mode = edge_mode_e'(wr_edge_i);
            st_d.nreq = wr_nreq_i;
        end
        if (ovr_set)        st_d.ovr = 1'b1;
        else if (ovr_clr_i) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovr_o = st_q.ovr;
    assign ie_o  = st_q.ie;
    assign en_o  = st_q.en;

endmodule

// File: rtl/trg_burst_reqgen.sv
`timescale 1ns/1ps
module trg_burst_reqgen #(
    parameter int NUM_GEN = 4,
    parameter int TRIG_W  = 26,
    parameter int CNT_W   = 5,
    localparam int SEL_W  = $clog2(TRIG_W),
    localparam int IDX_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_en,
    input  logic [SEL_W-1:0]   cfg_trig_sel,
    input  logic [1:0]         cfg_edge,
    input  logic [CNT_W-1:0]   cfg_nreq,
    input  logic               cfg_irq_en,
    input  logic [TRIG_W-1:0]  trig_i,
    input  logic [NUM_GEN-1:0] ovr_clr_i,
    input  logic [NUM_GEN-1:0] ack_i,
    output logic [NUM_GEN-1:0] req_o,
    output logic [NUM_GEN-1:0] ovr_o,
    output logic               irq_o
);
    logic [NUM_GEN-1:0] gen_ie;
    logic [NUM_GEN-1:0] gen_en;
    logic [NUM_GEN-1:0] gen_wr;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        assign gen_wr[g] = cfg_we && (cfg_idx == IDX_W'(g));

        trg_gen_chan #(.TRIG_W(TRIG_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (gen_wr[g]),
            .wr_en_i   (cfg_en),
            .wr_sel_i  (cfg_trig_sel),
            .wr_edge_i (cfg_edge),
            .wr_nreq_i (cfg_nreq),
            .wr_ie_i   (cfg_irq_en),
            .trig_i    (trig_i),
            .ovr_clr_i (ovr_clr_i[g]),
            .ack_i     (ack_i[g]),
            .req_o     (req_o[g]),
            .ovr_o     (ovr_o[g]),
            .ie_o      (gen_ie[g]),
            .en_o      (gen_en[g])
        );
    end

    assign irq_o = |(ovr_o & gen_ie);

endmodule

// File: rtl/trg_burst_reqgen_chk.sv
`timescale 1ns/1ps
module trg_burst_reqgen_chk #(
    parameter int NUM_GEN = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_GEN-1:0] req_o,
    input logic [NUM_GEN-1:0] ack_i,
    input logic [NUM_GEN-1:0] ovr_o,
    input logic [NUM_GEN-1:0] ovr_clr_i,
    input logic               irq_o,
    input logic [NUM_GEN-1:0] gen_en
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[g] && !ack_i[g] && gen_en[g]) |=> req_o[g]); // R4
        AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_en[g] |=> !req_o[g]); // R10
        AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr_o[g] && !ovr_clr_i[g]) |=> ovr_o[g]); // R8
        AST_OVR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr_o[g]) |-> $past(req_o[g])); // R7
        AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_o[g]) |-> $past(gen_en[g])); // R12
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovr_o != '0)); // R9

endmodule

bind trg_burst_reqgen trg_burst_reqgen_chk #(.NUM_GEN(NUM_GEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_o     (req_o),
    .ack_i     (ack_i),
    .ovr_o     (ovr_o),
    .ovr_clr_i (ovr_clr_i),
    .irq_o     (irq_o),
    .gen_en    (gen_en)
);

// File: tb/trg_burst_reqgen_tb_top.sv
`timescale 1ns/1ps
module trg_burst_reqgen_tb_top;
    localparam int NG = 4;
    localparam int TW = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic cfg_en = 1'b0;
    logic [4:0] cfg_trig_sel = '0;
    logic [1:0] cfg_edge = '0;
    logic [4:0] cfg_nreq = '0;
    logic cfg_irq_en = 1'b0;
    logic [TW-1:0] trig = '0;
    logic [NG-1:0] ovr_clr = '0;
    logic [NG-1:0] ack = '0;
    logic [NG-1:0] req;
    logic [NG-1:0] ovr;
    logic irq;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    bit m_en[NG], m_ie[NG], m_prev[NG], m_req[NG], m_ovr[NG];
    int m_sel[NG], m_mode[NG], m_nreq[NG], m_left[NG];

    always #2.5 clk = ~clk;

    trg_burst_reqgen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_trig_sel(cfg_trig_sel), .cfg_edge(cfg_edge),
        .cfg_nreq(cfg_nreq), .cfg_irq_en(cfg_irq_en), .trig_i(trig),
        .ovr_clr_i(ovr_clr), .ack_i(ack), .req_o(req), .ovr_o(ovr), .irq_o(irq)
    );

    function automatic bit line_at(int s);
        return (s < TW) ? trig[s] : 1'b0;
    endfunction

    function automatic bit edge_ok(int mode, bit cur, bit prev);
        case (mode)
            1: return cur && !prev;
            2: return !cur && prev;
            3: return cur != prev;
            default: return 1'b0;
        endcase
    endfunction

    function automatic void model_reset();
        for (int g = 0; g < NG; g++) begin
            m_en[g] = 0; m_ie[g] = 0; m_prev[g] = 0; m_req[g] = 0; m_ovr[g] = 0;
            m_sel[g] = 0; m_mode[g] = 0; m_nreq[g] = 0; m_left[g] = 0;
        end
    endfunction

    function automatic void model_step();
        for (int g = 0; g < NG; g++) begin
            bit wr, cur, hit, n_req, n_ovr;
            int n_left;
            wr = cfg_we && (int'(cfg_idx) == g);
            cur = line_at(m_sel[g]);
            hit = m_en[g] && !wr && edge_ok(m_mode[g], cur, m_prev[g]);
            n_req = m_req[g];
            n_left = m_left[g];
            n_ovr = m_ovr[g];
            if (!m_en[g]) begin
                n_req = 0; n_left = 0;
            end else if (m_req[g]) begin
                if (ack[g]) begin
                    if (m_left[g] == 0) n_req = 0;
                    else n_left = m_left[g] - 1;
                end
            end else if (hit) begin
                n_req = 1; n_left = m_nreq[g];
            end
            if (hit && m_req[g]) n_ovr = 1;
            else if (ovr_clr[g]) n_ovr = 0;
            m_prev[g] = wr ? line_at(int'(cfg_trig_sel)) : cur;
            m_req[g] = n_req;
            m_left[g] = n_left;
            m_ovr[g] = n_ovr;
            if (wr) begin
                m_en[g] = cfg_en; m_ie[g] = cfg_irq_en; m_sel[g] = int'(cfg_trig_sel);
                m_mode[g] = int'(cfg_edge); m_nreq[g] = int'(cfg_nreq);
            end
        end
    endfunction

    task automatic compare(string tag);
        logic [NG-1:0] er, eo;
        logic ei;
        ei = 1'b0;
        for (int g = 0; g < NG; g++) begin
            er[g] = m_req[g];
            eo[g] = m_ovr[g];
            ei = ei | (m_ovr[g] & m_ie[g]);
        end
        checks += 3;
        if (req !== er) begin bad++; $display("FAIL %s req actual=%b expected=%b", tag, req, er); end
        if (ovr !== eo) begin bad++; $display("FAIL %s ovr actual=%b expected=%b", tag, ovr, eo); end
        if (irq !== ei) begin bad++; $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei); end
    endtask

    // inputs set at negedge; model advanced with them; compare after the edge
    task automatic step(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        cfg_we = 1'b0;
        ovr_clr = '0;
        ack = '0;
    endtask

    task automatic wcfg(int idx, bit en, int sel, int mode, int nreq, bit ie);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_en = en; cfg_trig_sel = 5'(sel);
        cfg_edge = 2'(mode); cfg_nreq = 5'(nreq); cfg_irq_en = ie;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // generator 0: line 3, rising, 3 requests, irq enabled
        wcfg(0, 1, 3, 1, 2, 1); step("R11");
        trig[3] = 1; step("R12");
        step("R4"); step("R4");
        ack[0] = 1; step("R5");
        ack[0] = 1; step("R5");
        ack[0] = 1; step("R4");
        ack[0] = 1; step("R6");
        step("R6");

        // other lines leave generator 0 idle
        trig[4] = 1; step("R2"); trig[4] = 0; step("R2");
        wcfg(3, 1, 30, 3, 0, 0); step("R2");
        trig[25] = 1; step("R2"); step("R2");

        // edge modes
        wcfg(1, 1, 7, 2, 0, 0); step("R3");
        trig[7] = 1; step("R3");
        trig[7] = 0; step("R3");
        ack[1] = 1; step("R3");
        wcfg(2, 1, 9, 3, 0, 1); step("R3");
        trig[9] = 1; step("R3"); ack[2] = 1; step("R3");
        trig[9] = 0; step("R3"); ack[2] = 1; step("R3");
        wcfg(2, 1, 9, 0, 0, 1); step("R3");
        trig[9] = 1; step("R3"); step("R3");

        // overrun while busy; burst keeps its count
        trig[3] = 0; step("R7");
        trig[3] = 1; step("R7");
        trig[3] = 0; step("R7");
        trig[3] = 1; step("R7");
        step("R9");
        ack[0] = 1; step("R7"); ack[0] = 1; step("R7"); ack[0] = 1; step("R7");
        ovr_clr[0] = 1; step("R8");
        step("R9");

        // overrun on last acknowledge, and clear colliding with set
        trig[3] = 0; step("R7");
        trig[3] = 1; step("R7");
        ack[0] = 1; step("R7"); ack[0] = 1; step("R7");
        ack[0] = 1; trig[3] = 0; step("R7");
        trig[3] = 1; step("R7");
        trig[3] = 0; ovr_clr[0] = 1; step("R8");
        ovr_clr[0] = 1; step("R8");

        // generator 1 overrun with irq masked
        trig[7] = 1; step("R9"); trig[7] = 0; step("R9");
        trig[7] = 1; step("R9"); trig[7] = 0; step("R9");
        ack[1] = 1; step("R9"); ack[1] = 1; step("R9");

        // disable in the middle of a burst
        wcfg(0, 1, 3, 3, 5, 1); step("R10");
        trig[3] = 1; step("R10");
        wcfg(0, 0, 3, 3, 5, 1); step("R10");
        step("R10");
        trig[3] = 0; step("R10"); trig[3] = 1; step("R10");

        // edge in the write cycle is ignored; new line sampled
        trig[12] = 1;
        wcfg(0, 1, 12, 3, 0, 1); trig[3] = 0; step("R11");
        step("R11");
        trig[12] = 0; step("R11"); ack[0] = 1; step("R11");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 3) == 0) trig[$urandom_range(0, 11)] ^= 1'b1;
            ack = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            if ($urandom_range(0, 30) == 0) ovr_clr = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 60) == 0)
                wcfg($urandom_range(0, 3), $urandom_range(0, 5) != 0, $urandom_range(0, 13),
                     $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            step("R4");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule